// File: doc/BRIEF.md
# CPU Exception Request Arbiter

This block gathers every exception and interrupt request that a small processor core can see in a cycle. It masks each request according to the current processor status and picks the single most urgent survivor. The chosen event goes to the pipeline as a one-cycle take strobe, together with a cause code, a vector index, the new interrupt level and a flag that marks events the core must never return from. Saving context, fetching the handler address and returning from a handler are done elsewhere.

Acceptance is a simple hold-off handshake rather than a stream interface. After a take, the arbiter stops accepting and waits until the pipeline raises `entry_ack` to confirm it has entered the handler. Requests that are still pending then compete again on the next edge. A reset request is the only exception: it is accepted even while the arbiter is waiting. All outputs are registered, so a request sampled on one rising edge shows on the outputs just after that same edge.

Cause codes: 0 reset, 1 non-maskable interrupt, 2 instruction-fetch fault, 3 undefined instruction, 4 privileged instruction, 5 floating-point event, 6 operand fault, 7 trap, 8 normal interrupt, 9 fast interrupt.

Top module: `exc_arbiter`

## Requirements
- R1: A high `reset_req` is always accepted, even while the arbiter is waiting for `entry_ack`. It gives code 0, vector 0 and level 0, and it wins over every other request.
- R2: `nmi_req` is accepted whatever the value of `int_enable`. It gives code 1 and vector 1, and `non_resumable` is 1 on exactly those takes.
- R3: When `int_enable` is 0, neither a normal nor a fast interrupt request is accepted.
- R4: When `fast_sel` is 1, the interrupt request is treated as level 15 (all ones), whatever `irq_level` says. It gives code 9, vector `irq_vec` and `take_level` 15.
- R5: `priv_flag` is accepted only while `user_mode` is 1. It gives code 4 and vector 4.
- R6: `ifetch_fault` gives code 2 and vector 2. `operand_fault` gives code 6 and vector 6.
- R7: Bit i of `fp_events` counts only when bit i of `fp_enables` is 1. The bits are, from 0 to 5: overflow, underflow, inexact, divide-by-zero, invalid, unimplemented. A take gives code 5 and vector 16+i, where i is the lowest bit that is both set and enabled.
- R8: `trap_req` cannot be masked. It gives code 7 and vector `trap_vec`.
- R9: Priority from highest to lowest: reset, NMI, instruction-fetch fault, undefined instruction, privileged instruction, floating-point, operand fault, trap, interrupt. `undef_flag` gives code 3 and vector 3.
- R10: A normal interrupt is accepted only if `irq_level` is strictly greater than `cur_ipl`. It gives code 8, vector `irq_vec` and `take_level` equal to `irq_level`. A fast interrupt is likewise refused when `cur_ipl` is 15.
- R11: `take` is low after reset and is a single-cycle pulse. After a take, every request except reset is ignored up to and including the edge at which `entry_ack` is sampled high. At that edge the arbiter becomes free, and it can take again on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the arbiter itself |
| reset_req | input | 1 | Core reset request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | Prioritised maskable interrupt request |
| irq_level | input | 4 | Level of the maskable interrupt |
| irq_vec | input | 8 | Vector index of the maskable interrupt |
| fast_sel | input | 1 | The pending interrupt is the fast one |
| undef_flag | input | 1 | Undefined instruction decoded |
| priv_flag | input | 1 | Privileged instruction decoded |
| ifetch_fault | input | 1 | Instruction-fetch protection violation |
| operand_fault | input | 1 | Data protection violation |
| fp_events | input | 6 | Floating-point event flags |
| fp_enables | input | 6 | Per-event floating-point enable bits |
| trap_req | input | 1 | Unconditional trap instruction executed |
| trap_vec | input | 8 | Vector index of the trap |
| user_mode | input | 1 | 1 = user mode, 0 = supervisor mode |
| int_enable | input | 1 | Interrupt-enable status bit |
| cur_ipl | input | 4 | Current processor interrupt priority level |
| entry_ack | input | 1 | Pipeline has entered the handler |
| take | output | 1 | One-cycle acceptance strobe |
| take_code | output | 4 | Cause code of the accepted event |
| take_vector | output | 8 | Vector index of the accepted event |
| take_level | output | 4 | New interrupt level (0 for non-interrupt causes) |
| non_resumable | output | 1 | Accepted event must not be returned from |

## Verification
Two functions can fall in the same cycle: the hold-off that follows a take, and the acceptance of a fresh request. The bench sets this up in two ways. In the first, it raises a reset request while a non-maskable request is still waiting for acknowledgement; reset must be taken at once. In the second, it keeps a non-maskable request held high through the acknowledge cycle; there must be no take on the acknowledge edge and a take on the edge after it. It also applies several sources together to show that each priority step picks the higher-ranked source.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int NSRC   = 10;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET   = 4'd0,
    EXC_NMI     = 4'd1,
    EXC_IFETCH  = 4'd2,
    EXC_UNDEF   = 4'd3,
    EXC_PRIV    = 4'd4,
    EXC_FPU     = 4'd5,
    EXC_OPERAND = 4'd6,
    EXC_TRAP    = 4'd7,
    EXC_IRQ     = 4'd8,
    EXC_FASTIRQ = 4'd9
  } exc_code_e;
endpackage

// File: rtl/exc_first_set.sv
// Lowest-index-wins encoder; index 0 is the most urgent input.
module exc_first_set #(
  parameter int N  = 10,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/exc_src_gate.sv
// Applies per-source masking. The request vector is indexed by cause code.
module exc_src_gate
  import exc_arb_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int FP_N  = 6
) (
  input  logic             reset_req,
  input  logic             nmi_req,
  input  logic             irq_req,
  input  logic [LVL_W-1:0] irq_level,
  input  logic             fast_sel,
  input  logic             undef_flag,
  input  logic             priv_flag,
  input  logic             ifetch_fault,
  input  logic             operand_fault,
  input  logic [FP_N-1:0]  fp_events,
  input  logic [FP_N-1:0]  fp_enables,
  input  logic             trap_req,
  input  logic             user_mode,
  input  logic             int_enable,
  input  logic [LVL_W-1:0] cur_ipl,
  output logic [NSRC-1:0]  req,
  output logic [FP_N-1:0]  fp_live,
  output logic [LVL_W-1:0] irq_new_lvl
);
  logic irq_ok;

  assign fp_live     = fp_events & fp_enables;
  assign irq_new_lvl = fast_sel ? {LVL_W{1'b1}} : irq_level;
  assign irq_ok      = irq_req && int_enable && (irq_new_lvl > cur_ipl);

  always_comb begin
    req              = '0;
    req[EXC_RESET]   = reset_req;
    req[EXC_NMI]     = nmi_req;
    req[EXC_IFETCH]  = ifetch_fault;
    req[EXC_UNDEF]   = undef_flag;
    req[EXC_PRIV]    = priv_flag && user_mode;
    req[EXC_FPU]     = |fp_live;
    req[EXC_OPERAND] = operand_fault;
    req[EXC_TRAP]    = trap_req;
    req[EXC_IRQ]     = irq_ok && !fast_sel;
    req[EXC_FASTIRQ] = irq_ok && fast_sel;
  end
endmodule

// File: rtl/exc_take_ctrl.sv
// Registers the chosen event and holds off further takes until acknowledged.
module exc_take_ctrl #(
  parameter int CODE_W = 4,
  parameter int VEC_W  = 8,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic              reset_hit,
  input  logic              entry_ack,
  input  logic [CODE_W-1:0] sel_code,
  input  logic [VEC_W-1:0]  sel_vec,
  input  logic [LVL_W-1:0]  sel_lvl,
  input  logic              sel_nr,
  output logic              take,
  output logic [CODE_W-1:0] take_code,
  output logic [VEC_W-1:0]  take_vector,
  output logic [LVL_W-1:0]  take_level,
  output logic              non_resumable
);
  logic waiting;
  logic accept;

  assign accept = reset_hit || (!waiting && any);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting       <= 1'b0;
      take          <= 1'b0;
      take_code     <= '0;
      take_vector   <= '0;
      take_level    <= '0;
      non_resumable <= 1'b0;
    end else begin
      take <= accept;
      if (accept) begin
        waiting       <= 1'b1;
        take_code     <= sel_code;
        take_vector   <= sel_vec;
        take_level    <= sel_lvl;
        non_resumable <= sel_nr;
      end else if (waiting && entry_ack) begin
        waiting <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_arb_pkg::*;
#(
  parameter int LVL_W       = 4,
  parameter int VEC_W       = 8,
  parameter int FP_N        = 6,
  parameter int FP_VEC_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req,
  input  logic              nmi_req,
  input  logic              irq_req,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              fast_sel,
  input  logic              undef_flag,
  input  logic              priv_flag,
  input  logic              ifetch_fault,
  input  logic              operand_fault,
  input  logic [FP_N-1:0]   fp_events,
  input  logic [FP_N-1:0]   fp_enables,
  input  logic              trap_req,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic              user_mode,
  input  logic              int_enable,
  input  logic [LVL_W-1:0]  cur_ipl,
  input  logic              entry_ack,
  output logic              take,
  output logic [CODE_W-1:0] take_code,
  output logic [VEC_W-1:0]  take_vector,
  output logic [LVL_W-1:0]  take_level,
  output logic              non_resumable
);
  localparam int SRC_IW = $clog2(NSRC);
  localparam int FP_IW  = (FP_N > 1) ? $clog2(FP_N) : 1;

  logic [NSRC-1:0]   req;
  logic [FP_N-1:0]   fp_live;
  logic [LVL_W-1:0]  irq_new_lvl;
  logic              any, fp_any;
  logic [SRC_IW-1:0] src_idx;
  logic [FP_IW-1:0]  fp_idx;
  logic [CODE_W-1:0] sel_code;
  logic [VEC_W-1:0]  sel_vec;
  logic [LVL_W-1:0]  sel_lvl;
  logic              sel_nr;

  exc_src_gate #(.LVL_W(LVL_W), .FP_N(FP_N)) u_gate (
    .reset_req(reset_req), .nmi_req(nmi_req), .irq_req(irq_req),
    .irq_level(irq_level), .fast_sel(fast_sel), .undef_flag(undef_flag),
    .priv_flag(priv_flag), .ifetch_fault(ifetch_fault),
    .operand_fault(operand_fault), .fp_events(fp_events),
    .fp_enables(fp_enables), .trap_req(trap_req), .user_mode(user_mode),
    .int_enable(int_enable), .cur_ipl(cur_ipl), .req(req),
    .fp_live(fp_live), .irq_new_lvl(irq_new_lvl)
  );

  exc_first_set #(.N(NSRC), .IW(SRC_IW)) u_src_pick (
    .req(req), .any(any), .idx(src_idx)
  );

  exc_first_set #(.N(FP_N), .IW(FP_IW)) u_fp_pick (
    .req(fp_live), .any(fp_any), .idx(fp_idx)
  );

  always_comb begin
    sel_code = CODE_W'(src_idx);
    sel_lvl  = '0;
    sel_nr   = 1'b0;
    case (sel_code)
      EXC_FPU:  sel_vec = fp_any ? VEC_W'(FP_VEC_BASE) + VEC_W'(fp_idx) : VEC_W'(FP_VEC_BASE);
      EXC_TRAP: sel_vec = trap_vec;
      EXC_IRQ, EXC_FASTIRQ: begin
        sel_vec = irq_vec;
        sel_lvl = irq_new_lvl;
      end
      EXC_NMI: begin
        sel_vec = VEC_W'(sel_code);
        sel_nr  = 1'b1;
      end
      default:  sel_vec = VEC_W'(sel_code);
    endcase
  end

  exc_take_ctrl #(.CODE_W(CODE_W), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_take (
    .clk(clk), .rst_n(rst_n), .any(any), .reset_hit(req[EXC_RESET]),
    .entry_ack(entry_ack), .sel_code(sel_code), .sel_vec(sel_vec),
    .sel_lvl(sel_lvl), .sel_nr(sel_nr), .take(take), .take_code(take_code),
    .take_vector(take_vector), .take_level(take_level),
    .non_resumable(non_resumable)
  );
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk #(
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reset_req,
  input logic             nmi_req,
  input logic             user_mode,
  input logic             int_enable,
  input logic [LVL_W-1:0] cur_ipl,
  input logic             entry_ack,
  input logic             take,
  input logic [3:0]       take_code,
  input logic [LVL_W-1:0] take_level,
  input logic             non_resumable
);
  logic pv;
  logic pend;
  logic active;

  assign active = pend || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv   <= 1'b0;
      pend <= 1'b0;
    end else begin
      pv <= 1'b1;
      if (active && entry_ack && !take) pend <= 1'b0;
      else if (take && entry_ack)      pend <= 1'b0;
      else if (take)                   pend <= 1'b1;
    end
  end

  a_r1_reset_taken: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(reset_req) |-> take && take_code == 4'd0);

  a_r2_nmi_flag: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (non_resumable == (take_code == 4'd1)));

  a_r3_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    pv && take && (take_code == 4'd8 || take_code == 4'd9) |-> $past(int_enable));

  a_r4_fast_top: assert property (@(posedge clk) disable iff (!rst_n)
    take && take_code == 4'd9 |-> take_level == {LVL_W{1'b1}});

  a_r5_priv_user: assert property (@(posedge clk) disable iff (!rst_n)
    pv && take && take_code == 4'd4 |-> $past(user_mode));

  a_r9_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(nmi_req) && !$past(reset_req) && !$past(active) |-> take && take_code == 4'd1);

  a_r10_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
    pv && take && take_code == 4'd8 |-> take_level > $past(cur_ipl));

  a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    active && !reset_req |=> !take);
endmodule

bind exc_arbiter exc_arbiter_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/exc_arbiter_tb_top.sv
`timescale 1ns/1ps
module exc_arbiter_tb_top;
  typedef struct {
    bit         tk;
    logic [3:0] code;
    logic [7:0] vec;
    logic [3:0] lvl;
    logic       nr;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_req, nmi_req, irq_req, fast_sel, undef_flag, priv_flag;
  logic ifetch_fault, operand_fault, trap_req, user_mode, int_enable, entry_ack;
  logic [3:0] irq_level, cur_ipl;
  logic [7:0] irq_vec, trap_vec;
  logic [5:0] fp_events, fp_enables;
  logic       take, non_resumable;
  logic [3:0] take_code, take_level;
  logic [7:0] take_vector;

  exp_t exp_q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vec(irq_vec),
    .fast_sel(fast_sel), .undef_flag(undef_flag), .priv_flag(priv_flag),
    .ifetch_fault(ifetch_fault), .operand_fault(operand_fault),
    .fp_events(fp_events), .fp_enables(fp_enables), .trap_req(trap_req),
    .trap_vec(trap_vec), .user_mode(user_mode), .int_enable(int_enable),
    .cur_ipl(cur_ipl), .entry_ack(entry_ack), .take(take),
    .take_code(take_code), .take_vector(take_vector), .take_level(take_level),
    .non_resumable(non_resumable)
  );

  // Monitor: compares each registered result shortly after the edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (take !== e.tk ||
            (e.tk && (take_code !== e.code || take_vector !== e.vec ||
                      take_level !== e.lvl || non_resumable !== e.nr))) begin
          n_bad++;
          $display("FAIL %s: got take=%0b code=%0d vec=%0d lvl=%0d nr=%0b, expected take=%0b code=%0d vec=%0d lvl=%0d nr=%0b",
                   e.tag, take, take_code, take_vector, take_level, non_resumable,
                   e.tk, e.code, e.vec, e.lvl, e.nr);
        end
      end else if (take) begin
        n_bad++;
        $display("FAIL R11: got unexpected take code=%0d, expected no take", take_code);
      end
    end
  end

  task automatic clr();
    reset_req = 0; nmi_req = 0; irq_req = 0; fast_sel = 0; undef_flag = 0;
    priv_flag = 0; ifetch_fault = 0; operand_fault = 0; trap_req = 0;
    user_mode = 0; int_enable = 0; entry_ack = 0; irq_level = 0; cur_ipl = 0;
    irq_vec = 8'h00; trap_vec = 8'h00; fp_events = 0; fp_enables = 0;
  endtask

  // Driver: queues the result expected for the inputs applied in this cycle.
  task automatic step(input bit tk, input int code, input int vec,
                      input int lvl, input bit nr, input string tag);
    exp_t e;
    e.tk = tk; e.code = 4'(code); e.vec = 8'(vec); e.lvl = 4'(lvl);
    e.nr = nr; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic ack();
    clr();
    entry_ack = 1;
    step(0, 0, 0, 0, 0, "R11 ack");
    entry_ack = 0;
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0, 0, "R11 reset state");

    // R1: reset beats everything
    reset_req = 1; nmi_req = 1; trap_req = 1; ifetch_fault = 1;
    step(1, 0, 0, 0, 0, "R1 reset wins");
    ack();

    // R2: NMI with interrupts disabled
    nmi_req = 1; irq_req = 1; irq_level = 9;
    step(1, 1, 1, 0, 1, "R2 nmi unmasked");
    ack();

    // R3: masked interrupts
    irq_req = 1; irq_level = 5; irq_vec = 8'h33;
    step(0, 0, 0, 0, 0, "R3 irq masked");
    fast_sel = 1;
    step(0, 0, 0, 0, 0, "R3 fast masked");

    // R10: strict level compare
    clr(); int_enable = 1; irq_req = 1; irq_level = 5; cur_ipl = 5; irq_vec = 8'h33;
    step(0, 0, 0, 0, 0, "R10 equal level refused");
    irq_level = 6;
    step(1, 8, 8'h33, 6, 0, "R10 higher level taken");
    ack();

    // R4: fast interrupt forced to top level
    int_enable = 1; irq_req = 1; fast_sel = 1; irq_level = 2; cur_ipl = 14; irq_vec = 8'h5a;
    step(1, 9, 8'h5a, 15, 0, "R4 fast at level 15");
    ack();
    int_enable = 1; irq_req = 1; fast_sel = 1; cur_ipl = 15;
    step(0, 0, 0, 0, 0, "R10 fast refused at ipl 15");

    // R5: privileged instruction only in user mode
    clr(); priv_flag = 1;
    step(0, 0, 0, 0, 0, "R5 supervisor no exception");
    user_mode = 1;
    step(1, 4, 4, 0, 0, "R5 user mode");
    ack();

    // R6: the two protection faults
    ifetch_fault = 1;
    step(1, 2, 2, 0, 0, "R6 fetch fault");
    ack();
    operand_fault = 1;
    step(1, 6, 6, 0, 0, "R6 operand fault");
    ack();

    // R7: floating-point gating and event index
    fp_events = 6'b001000;
    step(0, 0, 0, 0, 0, "R7 disabled event");
    fp_events = 6'b101100; fp_enables = 6'b100100;
    step(1, 5, 18, 0, 0, "R7 lowest enabled event");
    ack();

    // R8: trap ignores masks
    trap_req = 1; trap_vec = 8'h40;
    step(1, 7, 8'h40, 0, 0, "R8 trap");
    ack();

    // R9: priority ladder
    ifetch_fault = 1; undef_flag = 1; priv_flag = 1; user_mode = 1; fp_events = 1;
    fp_enables = 1; operand_fault = 1; trap_req = 1; int_enable = 1; irq_req = 1; irq_level = 3;
    step(1, 2, 2, 0, 0, "R9 fetch over rest");
    ack();
    undef_flag = 1; priv_flag = 1; user_mode = 1; fp_events = 1; fp_enables = 1;
    step(1, 3, 3, 0, 0, "R9 undefined over privileged");
    ack();
    priv_flag = 1; user_mode = 1; fp_events = 1; fp_enables = 1; operand_fault = 1;
    step(1, 4, 4, 0, 0, "R9 privileged over fp");
    ack();
    fp_events = 1; fp_enables = 1; operand_fault = 1; trap_req = 1; trap_vec = 8'h41;
    step(1, 5, 16, 0, 0, "R9 fp over operand");
    ack();
    operand_fault = 1; trap_req = 1; int_enable = 1; irq_req = 1; irq_level = 3;
    step(1, 6, 6, 0, 0, "R9 operand over trap");
    ack();
    trap_req = 1; trap_vec = 8'h42; int_enable = 1; irq_req = 1; irq_level = 3; irq_vec = 8'h21;
    step(1, 7, 8'h42, 0, 0, "R9 trap over irq");
    ack();

    // R11: hold-off, reset during wait, acknowledge with pending request
    nmi_req = 1;
    step(1, 1, 1, 0, 1, "R2 nmi take");
    step(0, 0, 0, 0, 0, "R11 held no retake 1");
    step(0, 0, 0, 0, 0, "R11 held no retake 2");
    reset_req = 1;
    step(1, 0, 0, 0, 0, "R1 reset during wait");
    reset_req = 0;
    step(0, 0, 0, 0, 0, "R11 wait after reset take");
    entry_ack = 1;
    step(0, 0, 0, 0, 0, "R11 ack edge no take");
    entry_ack = 0;
    step(1, 1, 1, 0, 1, "R11 take after ack");
    ack();

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got no completion, expected end of sequence");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule